// File: doc/BRIEF.md
# Raster Timing Generator with Interlaced Field Sequencing

This block produces the horizontal and vertical timing for a raster display from a single reference clock. A programmable integer divider turns the reference clock into a one-cycle pixel enable. A pixel counter and a line counter advance on that enable. They wrap at programmable totals and are decoded against programmable sync and active windows. The outputs are horizontal and vertical sync, a display-active strobe, the current coordinates and a field flag.

In progressive operation every frame is identical and the field flag stays at odd. In interlaced operation the line counter runs one field per vertical total, and the field flag alternates between odd and even. Each field covers half the programmed active height. The screen raster number is reported as 2·line+1 in the odd field and 2·line+2 in the even field, so odd screen rasters fall in the odd field and even ones in the even field.

All configuration inputs are captured into shadow registers during reset and at each frame start. Software can therefore rewrite them at any time without tearing the frame in progress. The reset is synchronous and active high.

Top module: `raster_timing_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `pix_x`=0, `line_y`=0, `field_odd`=1 and `scr_raster`=1, and the divider phase is cleared.
- R2: `pix_en` is high on one reference cycle out of every N, where N is the captured `div_ratio`. A ratio of 0 or 1 makes `pix_en` high on every cycle.
- R3: `pix_x` holds when `pix_en` is low. On `pix_en` it increments, and it returns to 0 after reaching `h_total`-1.
- R4: `line_y` changes only when `pix_x` wraps. It increments at that point and returns to 0 after reaching `v_total`-1.
- R5: `hsync` is 1 exactly when `h_sync_start` <= `pix_x` < `h_sync_start`+`h_sync_len`, with the default active-high polarity.
- R6: `vsync` is 1 exactly when `v_sync_start` <= `line_y` < `v_sync_start`+`v_sync_len`.
- R7: `disp_act` is 1 only when `pix_x` lies in [`h_act_start`, `h_act_start`+`h_act_len`) and `line_y` lies in [`v_act_start`, `v_act_start`+H). H is `v_act_len` in progressive mode and `v_act_len`/2 (rounded down) in interlaced mode.
- R8: In progressive mode `field_odd` is 1. In interlaced mode it inverts at every frame start, beginning with odd (1) after reset or after a switch into interlaced mode. It changes only where both counters are 0.
- R9: `scr_raster` equals `line_y`+1 in progressive mode, 2·`line_y`+1 in the odd field and 2·`line_y`+2 in the even field. Its bit 0 therefore equals `field_odd` when interlaced.
- R10: All configuration inputs (ratio, mode, totals and windows) take effect only at reset or at the pixel-enable cycle where both counters wrap. A change in the middle of a frame does not alter that frame's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| div_ratio | input | DIV_W | Reference cycles per pixel |
| interlace_en | input | 1 | 1 selects interlaced scanning |
| h_total | input | H_W | Pixels per line |
| h_sync_start | input | H_W | First pixel of horizontal sync |
| h_sync_len | input | H_W | Horizontal sync width in pixels |
| h_act_start | input | H_W | First active pixel |
| h_act_len | input | H_W | Active pixels per line |
| v_total | input | V_W | Lines per frame or field |
| v_sync_start | input | V_W | First line of vertical sync |
| v_sync_len | input | V_W | Vertical sync width in lines |
| v_act_start | input | V_W | First active line |
| v_act_len | input | V_W | Active screen rasters (halved per field when interlaced) |
| pix_en | output | 1 | Pixel-rate enable |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| disp_act | output | 1 | Inside both active windows |
| field_odd | output | 1 | 1 for the odd field |
| pix_x | output | H_W | Pixel counter |
| line_y | output | V_W | Line counter within the field |
| scr_raster | output | V_W+1 | Screen raster number, counted from 1 |

## Verification
The assertions check, on every cycle, the local stepping rules. These are that the pixel counter holds between enables and otherwise steps by one or wraps to zero, that the line counter moves only at a line wrap, that the field flag moves only at the origin and stays odd in progressive mode, that the raster parity matches the field, and that ratios of 0 and 1 give a continuous enable. The exact places where the totals wrap, the positions of the sync and active windows, the halving of the active height per field, and the deferral of register changes to the frame start depend on the programmed values. Only the bench's scenarios show these, by comparing against its behavioural model under several ratios, totals and mid-frame rewrites.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

   typedef enum logic {
      FIELD_EVEN = 1'b0,
      FIELD_ODD  = 1'b1
   } field_e;

   localparam int SPAN_W = 16;

   // half-open window test: start <= pos < start + len, computed without wrap
   function automatic logic in_span(input logic [SPAN_W-1:0] pos,
                                    input logic [SPAN_W-1:0] start,
                                    input logic [SPAN_W-1:0] len);
      logic [SPAN_W:0] p, s, e;
      p = {1'b0, pos};
      s = {1'b0, start};
      e = s + {1'b0, len};
      return (p >= s) && (p < e);
   endfunction

endpackage

// File: rtl/rtg_clk_div.sv
module rtg_clk_div #(
   parameter int DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [DIV_W-1:0] ratio,
   output logic             pix_en,
   output logic [DIV_W-1:0] ratio_cur
);

   logic [DIV_W-1:0] ratio_q;

   always_ff @(posedge clk) begin
      if (rst || load) ratio_q <= ratio;
   end

   assign ratio_cur = ratio_q;

   generate
      if (DIV_W == 1) begin : g_trivial
         // only ratios 0 and 1 are representable: enable on every cycle
         assign pix_en = 1'b1;
      end else begin : g_counter
         logic [DIV_W-1:0] phase_q;
         logic             at_end;

         assign at_end = (ratio_q <= DIV_W'(1)) ||
                         (phase_q == ratio_q - DIV_W'(1));

         always_ff @(posedge clk) begin
            if (rst)         phase_q <= '0;
            else if (at_end) phase_q <= '0;
            else             phase_q <= phase_q + DIV_W'(1);
         end

         assign pix_en = at_end;
      end
   endgenerate

endmodule

// File: rtl/rtg_axis.sv
module rtg_axis #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic         step,
   input  logic [W-1:0] total,
   input  logic [W-1:0] sync_start,
   input  logic [W-1:0] sync_len,
   input  logic [W-1:0] act_start,
   input  logic [W-1:0] act_len,
   output logic [W-1:0] pos,
   output logic         wrap,
   output logic         sync_hit,
   output logic         act_hit
);

   localparam int SW = rtg_pkg::SPAN_W;

   logic [W-1:0] tot_q, ss_q, sl_q, as_q, al_q;

   always_ff @(posedge clk) begin
      if (rst || load) begin
         tot_q <= total;
         ss_q  <= sync_start;
         sl_q  <= sync_len;
         as_q  <= act_start;
         al_q  <= act_len;
      end
   end

   assign wrap = step && (pos == tot_q - W'(1));

   always_ff @(posedge clk) begin
      if (rst)       pos <= '0;
      else if (wrap) pos <= '0;
      else if (step) pos <= pos + W'(1);
   end

   assign sync_hit = rtg_pkg::in_span(SW'(pos), SW'(ss_q), SW'(sl_q));
   assign act_hit  = rtg_pkg::in_span(SW'(pos), SW'(as_q), SW'(al_q));

endmodule

// File: rtl/rtg_field.sv
module rtg_field #(
   parameter int V_W = 11
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           load,
   input  logic           ilace_in,
   input  logic [V_W-1:0] line,
   output logic           field_odd,
   output logic           ilace_cur,
   output logic [V_W:0]   scr_raster
);

   import rtg_pkg::*;

   field_e fld_q;
   logic   ilace_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ilace_q <= ilace_in;
         fld_q   <= FIELD_ODD;
      end else if (load) begin
         ilace_q <= ilace_in;
         // keep alternating only while interlace stays on; entering it starts odd
         if (ilace_in && ilace_q) fld_q <= (fld_q == FIELD_ODD) ? FIELD_EVEN : FIELD_ODD;
         else                     fld_q <= FIELD_ODD;
      end
   end

   assign field_odd = (fld_q == FIELD_ODD);
   assign ilace_cur = ilace_q;

   always_comb begin
      if (ilace_q)
         scr_raster = {line, 1'b0} + ((fld_q == FIELD_ODD) ? (V_W+1)'(1) : (V_W+1)'(2));
      else
         scr_raster = {1'b0, line} + (V_W+1)'(1);
   end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
   parameter int DIV_W           = 6,
   parameter int H_W             = 12,
   parameter int V_W             = 11,
   parameter bit SYNC_ACTIVE_LOW = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DIV_W-1:0] div_ratio,
   input  logic             interlace_en,
   input  logic [H_W-1:0]   h_total,
   input  logic [H_W-1:0]   h_sync_start,
   input  logic [H_W-1:0]   h_sync_len,
   input  logic [H_W-1:0]   h_act_start,
   input  logic [H_W-1:0]   h_act_len,
   input  logic [V_W-1:0]   v_total,
   input  logic [V_W-1:0]   v_sync_start,
   input  logic [V_W-1:0]   v_sync_len,
   input  logic [V_W-1:0]   v_act_start,
   input  logic [V_W-1:0]   v_act_len,
   output logic             pix_en,
   output logic             hsync,
   output logic             vsync,
   output logic             disp_act,
   output logic             field_odd,
   output logic [H_W-1:0]   pix_x,
   output logic [V_W-1:0]   line_y,
   output logic [V_W:0]     scr_raster
);

   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("raster_timing_gen: DIV_W must be 1..16");
      end
      if (H_W < 2 || H_W > rtg_pkg::SPAN_W) begin : g_bad_h
         $error("raster_timing_gen: H_W must be 2..16");
      end
      if (V_W < 2 || V_W > rtg_pkg::SPAN_W) begin : g_bad_v
         $error("raster_timing_gen: V_W must be 2..16");
      end
   endgenerate

   logic             frame_start;
   logic             h_wrap, v_wrap;
   logic             hs_hit, ha_hit, vs_hit, va_hit;
   logic [V_W-1:0]   va_len_eff;
   logic [DIV_W-1:0] ratio_cur;
   logic             ilace_cur;

   assign frame_start = v_wrap;
   assign va_len_eff  = interlace_en ? (v_act_len >> 1) : v_act_len;

   rtg_clk_div #(.DIV_W(DIV_W)) i_div (
      .clk       (clk),
      .rst       (rst),
      .load      (frame_start),
      .ratio     (div_ratio),
      .pix_en    (pix_en),
      .ratio_cur (ratio_cur)
   );

   rtg_axis #(.W(H_W)) i_hax (
      .clk        (clk),
      .rst        (rst),
      .load       (frame_start),
      .step       (pix_en),
      .total      (h_total),
      .sync_start (h_sync_start),
      .sync_len   (h_sync_len),
      .act_start  (h_act_start),
      .act_len    (h_act_len),
      .pos        (pix_x),
      .wrap       (h_wrap),
      .sync_hit   (hs_hit),
      .act_hit    (ha_hit)
   );

   rtg_axis #(.W(V_W)) i_vax (
      .clk        (clk),
      .rst        (rst),
      .load       (frame_start),
      .step       (h_wrap),
      .total      (v_total),
      .sync_start (v_sync_start),
      .sync_len   (v_sync_len),
      .act_start  (v_act_start),
      .act_len    (va_len_eff),
      .pos        (line_y),
      .wrap       (v_wrap),
      .sync_hit   (vs_hit),
      .act_hit    (va_hit)
   );

   rtg_field #(.V_W(V_W)) i_fld (
      .clk        (clk),
      .rst        (rst),
      .load       (frame_start),
      .ilace_in   (interlace_en),
      .line       (line_y),
      .field_odd  (field_odd),
      .ilace_cur  (ilace_cur),
      .scr_raster (scr_raster)
   );

   generate
      if (SYNC_ACTIVE_LOW) begin : g_sync_low
         assign hsync = ~hs_hit;
         assign vsync = ~vs_hit;
      end else begin : g_sync_high
         assign hsync = hs_hit;
         assign vsync = vs_hit;
      end
   endgenerate

   assign disp_act = ha_hit && va_hit;

endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
   parameter int DIV_W = 6,
   parameter int H_W   = 12,
   parameter int V_W   = 11
) (
   input logic             clk,
   input logic             rst,
   input logic             pix_en,
   input logic             field_odd,
   input logic [H_W-1:0]   pix_x,
   input logic [V_W-1:0]   line_y,
   input logic [V_W:0]     scr_raster,
   input logic [DIV_W-1:0] ratio_cur,
   input logic             ilace_cur
);

   a_r2_full_rate: assert property (@(posedge clk) disable iff (rst)
      (ratio_cur <= DIV_W'(1)) |-> pix_en);

   a_r3_hold_x: assert property (@(posedge clk) disable iff (rst)
      !pix_en |=> $stable(pix_x));

   a_r3_step_x: assert property (@(posedge clk) disable iff (rst)
      pix_en |=> ((pix_x == H_W'($past(pix_x) + 1'b1)) || (pix_x == '0)));

   a_r4_hold_y: assert property (@(posedge clk) disable iff (rst)
      !pix_en |=> $stable(line_y));

   a_r4_y_at_wrap: assert property (@(posedge clk) disable iff (rst)
      !$stable(line_y) |-> (pix_x == '0));

   a_r8_prog_odd: assert property (@(posedge clk) disable iff (rst)
      !ilace_cur |-> field_odd);

   a_r8_field_at_origin: assert property (@(posedge clk) disable iff (rst)
      !$stable(field_odd) |-> ((pix_x == '0) && (line_y == '0)));

   a_r9_parity: assert property (@(posedge clk) disable iff (rst)
      ilace_cur |-> (scr_raster[0] == field_odd));

endmodule

bind raster_timing_gen rtg_checker #(
   .DIV_W (DIV_W),
   .H_W   (H_W),
   .V_W   (V_W)
) i_rtg_checker (
   .clk        (clk),
   .rst        (rst),
   .pix_en     (pix_en),
   .field_odd  (field_odd),
   .pix_x      (pix_x),
   .line_y     (line_y),
   .scr_raster (scr_raster),
   .ratio_cur  (ratio_cur),
   .ilace_cur  (ilace_cur)
);

// File: tb/test_raster_timing_gen.sv
`timescale 1ns/1ps
module test_raster_timing_gen;

   localparam int DIV_W = 6;
   localparam int H_W   = 12;
   localparam int V_W   = 11;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic             rst;
   logic [DIV_W-1:0] div_ratio;
   logic             interlace_en;
   logic [H_W-1:0]   h_total, h_sync_start, h_sync_len, h_act_start, h_act_len;
   logic [V_W-1:0]   v_total, v_sync_start, v_sync_len, v_act_start, v_act_len;
   logic             pix_en, hsync, vsync, disp_act, field_odd;
   logic [H_W-1:0]   pix_x;
   logic [V_W-1:0]   line_y;
   logic [V_W:0]     scr_raster;

   raster_timing_gen #(.DIV_W(DIV_W), .H_W(H_W), .V_W(V_W)) i_raster_timing_gen (
      .clk(clk), .rst(rst), .div_ratio(div_ratio), .interlace_en(interlace_en),
      .h_total(h_total), .h_sync_start(h_sync_start), .h_sync_len(h_sync_len),
      .h_act_start(h_act_start), .h_act_len(h_act_len),
      .v_total(v_total), .v_sync_start(v_sync_start), .v_sync_len(v_sync_len),
      .v_act_start(v_act_start), .v_act_len(v_act_len),
      .pix_en(pix_en), .hsync(hsync), .vsync(vsync), .disp_act(disp_act),
      .field_odd(field_odd), .pix_x(pix_x), .line_y(line_y), .scr_raster(scr_raster)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit cmp_on = 1'b0;
   bit r10_on = 1'b0;

   // behavioural reference state
   int m_dc, m_h, m_v, m_fld;
   int s_div, s_ht, s_vt, s_hs0, s_hsw, s_ha0, s_haw, s_vs0, s_vsw, s_va0, s_vah, s_il;

   task automatic check1(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic capture_cfg();
      s_div = int'(div_ratio);   s_il  = int'(interlace_en);
      s_ht  = int'(h_total);     s_vt  = int'(v_total);
      s_hs0 = int'(h_sync_start); s_hsw = int'(h_sync_len);
      s_ha0 = int'(h_act_start); s_haw = int'(h_act_len);
      s_vs0 = int'(v_sync_start); s_vsw = int'(v_sync_len);
      s_va0 = int'(v_act_start); s_vah = int'(v_act_len);
   endtask

   function automatic int eff_ratio();
      return (s_div <= 1) ? 1 : s_div;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_dc = 0; m_h = 0; m_v = 0; m_fld = 1;
         capture_cfg();
      end else if (m_dc == eff_ratio() - 1) begin
         m_dc = 0;
         if (m_h == s_ht - 1) begin
            m_h = 0;
            if (m_v == s_vt - 1) begin
               m_v   = 0;
               m_fld = (interlace_en && s_il != 0) ? 1 - m_fld : 1;
               capture_cfg();
            end else begin
               m_v++;
            end
         end else begin
            m_h++;
         end
      end else begin
         m_dc++;
      end
   end

   always @(negedge clk) begin
      if (cmp_on) begin
         int e_en, e_hs, e_vs, e_act, e_scr, vh;
         vh    = (s_il != 0) ? s_vah / 2 : s_vah;
         e_en  = (m_dc == eff_ratio() - 1) ? 1 : 0;
         e_hs  = (m_h >= s_hs0 && m_h < s_hs0 + s_hsw) ? 1 : 0;
         e_vs  = (m_v >= s_vs0 && m_v < s_vs0 + s_vsw) ? 1 : 0;
         e_act = (m_h >= s_ha0 && m_h < s_ha0 + s_haw &&
                  m_v >= s_va0 && m_v < s_va0 + vh) ? 1 : 0;
         e_scr = (s_il != 0) ? 2 * m_v + ((m_fld != 0) ? 1 : 2) : m_v + 1;
         check1("R2 pix_en",     int'(pix_en),     e_en);
         check1("R3 pix_x",      int'(pix_x),      m_h);
         check1("R4 line_y",     int'(line_y),     m_v);
         check1("R5 hsync",      int'(hsync),      e_hs);
         check1("R6 vsync",      int'(vsync),      e_vs);
         check1("R7 disp_act",   int'(disp_act),   e_act);
         check1("R8 field_odd",  int'(field_odd),  m_fld);
         check1("R9 scr_raster", int'(scr_raster), e_scr);
         if (r10_on) begin
            check1("R10 hsync held to frame setting",    int'(hsync),    e_hs);
            check1("R10 disp_act held to frame setting", int'(disp_act), e_act);
         end
      end
   end

   task automatic reset_check();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check1("R1 pix_x after reset",     int'(pix_x),      0);
      check1("R1 line_y after reset",    int'(line_y),     0);
      check1("R1 field_odd after reset", int'(field_odd),  1);
      check1("R1 scr_raster after reset", int'(scr_raster), 1);
      rst = 1'b0;
   endtask

   task automatic run_to_origin();
      @(negedge clk);
      while (!(m_h == 0 && m_v == 0 && m_dc == 0)) @(negedge clk);
   endtask

   initial begin
      rst          = 1'b1;
      div_ratio    = 6'd3;  interlace_en = 1'b0;
      h_total      = 12'd20; h_sync_start = 12'd14; h_sync_len = 12'd3;
      h_act_start  = 12'd2;  h_act_len    = 12'd10;
      v_total      = 11'd12; v_sync_start = 11'd9;  v_sync_len = 11'd2;
      v_act_start  = 11'd1;  v_act_len    = 11'd6;
      reset_check();
      cmp_on = 1'b1;

      // progressive, divide by 3, two frames
      repeat (1500) @(negedge clk);

      // R10: rewrite windows mid-frame, old ones must hold until frame start
      while (m_v != 4) @(negedge clk);
      h_sync_start = 12'd5; h_act_len = 12'd8; v_act_len = 11'd9;
      r10_on = 1'b1;
      run_to_origin();
      r10_on = 1'b0;
      repeat (800) @(negedge clk);

      // interlaced at full rate (ratio 1), odd active height
      div_ratio = 6'd1; interlace_en = 1'b1; v_act_len = 11'd7;
      repeat (1500) @(negedge clk);

      // interlaced, divide by 5, different totals
      div_ratio = 6'd5; h_total = 12'd24; v_total = 11'd9;
      h_sync_start = 12'd18; h_sync_len = 12'd4; h_act_start = 12'd0; h_act_len = 12'd16;
      v_sync_start = 11'd6; v_sync_len = 11'd1; v_act_start = 11'd2; v_act_len = 11'd8;
      repeat (4500) @(negedge clk);

      // reset in the middle of a field, then progressive with ratio 0
      reset_check();
      repeat (200) @(negedge clk);
      div_ratio = 6'd0; interlace_en = 1'b0;
      repeat (1200) @(negedge clk);

      cmp_on = 1'b0;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule